// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block decides, every clock cycle, which waiting instructions leave the scheduler for execution. Instructions whose operands are already available are pushed in through several parallel lanes. Each push names an operation class, a sequence number (a smaller number means an older instruction) and a thread. Each class keeps its own small buffer and always offers its oldest entry. The classes are then visited in the order of the age of those oldest entries. Every visited class may issue one instruction per cycle, as long as the functional unit it needs is free.

There are four classes, and each is tied to a kind of execution resource. Class 0 needs no unit. Class 1 uses a single-cycle unit. Class 2 uses a pipelined multi-cycle unit that accepts new work every cycle. Class 3 uses one of two unpipelined units. Such a unit stays occupied until an internal completion fires, and only then is the instruction placed on the issue output. The issue output has a fixed number of slots. Completions are placed in the slots first, and fresh picks fill the slots that remain. Per-class and per-thread counters record each visit that found no free unit.

Top module: `iq_issue_select`

## Requirements
- R1: After reset, every issue slot is invalid, the issue count is 0 and all busy counters (per class and per thread) are 0.
- R2: Within a class, the entry with the smallest sequence number is chosen first, whatever the push order. A pushed entry can first be chosen in the cycle after the edge that captures it, so it reaches the output one further edge later.
- R3: Classes that hold an entry are visited in ascending order of their oldest sequence number, and each class issues at most one instruction per cycle. When an older entry is pushed into a class that is not empty, that class moves to the visit position its new oldest entry gives it.
- R4: Visiting stops once the picks of the cycle reach ISSUE_W (default 2) or every output slot is taken. Classes that were not visited keep their entries and are not counted as busy.
- R5: Class 0 issues without a unit. Class 1 (single-cycle) and class 2 (pipelined, one unit) free their unit for the next cycle, so class 2 can issue back to back and its busy counter stays 0.
- R6: A class 3 pick takes no output slot. Its instruction appears in the output exactly 3 edges after the edge that registers the pick (issue latency 4, minus one). Its unit can be picked again in the cycle after that completion edge.
- R7: The issue count output equals the number of picks made in the cycle. Class 3 picks are included, even though they fill no slot.
- R8: Completions take the lowest output slots, ahead of any pick of the same cycle, and reduce the slots left for picks.
- R9: A visited class whose units are all occupied adds 1 to its class busy counter and 1 to the busy counter of its oldest entry's thread, and visiting continues with the next class.
- R10: Picks that take a slot fill the slots after the completions, in visit order. Each slot carries the valid bit, the class (2 bits), the sequence number (8 bits) and the thread (1 bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_vld | input | PUSH_W | Per-lane push strobe for a ready instruction |
| push_cls | input | PUSH_W x 2 | Per-lane operation class |
| push_seq | input | PUSH_W x 8 | Per-lane sequence number (smaller is older) |
| push_tid | input | PUSH_W x 1 | Per-lane thread |
| iss_vld | output | ISSUE_W | Issue slot valid |
| iss_cls | output | ISSUE_W x 2 | Issue slot class |
| iss_seq | output | ISSUE_W x 8 | Issue slot sequence number |
| iss_tid | output | ISSUE_W x 1 | Issue slot thread |
| iss_count | output | $clog2(ISSUE_W+1) | Picks made in the previous cycle |
| busy_cls | output | 4 x CNT_W | Per-class count of visits that found no free unit |
| busy_thr | output | 2 x CNT_W | Per-thread count of visits that found no free unit |

## Verification
The checks assume that no class buffer receives a push while it is full. They also assume that sequence numbers stay unique and do not wrap while entries are live, since ordering is a plain unsigned compare. The stimulus stays within these limits: it pushes at most four entries into any class before that class drains, and it uses distinct, small, increasing sequence numbers. The class 3 scenarios are spaced so that at most one unpipelined completion falls in any cycle, which the output slot count can absorb.

// File: rtl/iss_pkg.sv
package iss_pkg;

    localparam int NUM_CLS = 4;
    localparam int CLS_W   = 2;
    localparam int SEQ_W   = 8;
    localparam int TID_W   = 1;
    localparam int NUM_THR = 2;

    typedef enum logic [1:0] {
        KIND_NOUNIT,
        KIND_SINGLE,
        KIND_PIPED,
        KIND_HELD
    } unit_kind_e;

    typedef struct packed {
        logic             vld;
        logic [CLS_W-1:0] cls;
        logic [SEQ_W-1:0] seq;
        logic [TID_W-1:0] tid;
    } uop_t;

    // Execution resource table, indexed by class
    function automatic int cls_units(input int c);
        case (c)
            0:       return 0;
            3:       return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int cls_op_lat(input int c);
        case (c)
            2:       return 3;
            3:       return 6;
            default: return 1;
        endcase
    endfunction

    function automatic int cls_iss_lat(input int c);
        return (c == 3) ? 4 : 1;
    endfunction

    function automatic unit_kind_e cls_kind(input int c);
        if (cls_units(c) == 0)        return KIND_NOUNIT;
        else if (cls_op_lat(c) == 1)  return KIND_SINGLE;
        else if (cls_iss_lat(c) > 1)  return KIND_HELD;
        else                          return KIND_PIPED;
    endfunction

endpackage

// File: rtl/iq_class_q.sv
module iq_class_q
    import iss_pkg::*;
#(
    parameter int CLS    = 0,
    parameter int DEPTH  = 4,
    parameter int PUSH_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  uop_t push_uop [PUSH_W],
    input  logic pop,
    output logic head_vld,
    output uop_t head_uop
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    uop_t             ent   [DEPTH];
    uop_t             ent_n [DEPTH];
    logic [IW-1:0]    head_idx;
    logic [DEPTH-1:0] taken;
    logic             placed;

    // Oldest valid entry; lowest index wins a tie
    always_comb begin
        head_vld = 1'b0;
        head_idx = '0;
        head_uop = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (ent[j].vld && (!head_vld || ent[j].seq < head_uop.seq)) begin
                head_vld = 1'b1;
                head_idx = IW'(j);
                head_uop = ent[j];
            end
        end
    end

    always_comb begin
        ent_n  = ent;
        placed = 1'b0;
        if (pop && head_vld)
            ent_n[head_idx].vld = 1'b0;
        for (int j = 0; j < DEPTH; j++)
            taken[j] = ent[j].vld;
        for (int l = 0; l < PUSH_W; l++) begin
            if (push_uop[l].vld && push_uop[l].cls == CLS_W'(CLS)) begin
                placed = 1'b0;
                for (int j = 0; j < DEPTH; j++) begin
                    if (!placed && !taken[j]) begin
                        ent_n[j] = push_uop[l];
                        taken[j] = 1'b1;
                        placed   = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++)
                ent[j] <= '0;
        end else begin
            for (int j = 0; j < DEPTH; j++)
                ent[j] <= ent_n[j];
        end
    end

endmodule

// File: rtl/iq_unit_pool.sv
module iq_unit_pool
    import iss_pkg::*;
#(
    parameter int CLS = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic grab,
    input  uop_t grab_uop,
    output logic avail,
    output logic done_vld,
    output uop_t done_uop
);

    localparam unit_kind_e KIND  = cls_kind(CLS);
    localparam bit         HOLDS = (KIND == KIND_HELD);
    localparam int         NU    = (cls_units(CLS) < 1) ? 1 : cls_units(CLS);
    localparam int         IL    = cls_iss_lat(CLS);
    localparam int         TW    = $clog2(IL + 1);

    logic [NU-1:0]         busy;
    logic [NU-1:0][TW-1:0] tmr;
    uop_t                  held [NU];
    logic [NU-1:0]         fin;
    logic [NU-1:0]         take;
    logic                  found;

    // Units that free next cycle never set busy, so they always look available
    always_comb begin
        found = 1'b0;
        for (int u = 0; u < NU; u++) begin
            fin[u]  = busy[u] && (tmr[u] == TW'(1));
            take[u] = 1'b0;
            if (HOLDS && grab && !busy[u] && !found) begin
                take[u] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    always_comb begin
        avail    = |(~busy);
        done_vld = 1'b0;
        done_uop = '0;
        for (int u = 0; u < NU; u++) begin
            if (fin[u] && !done_vld) begin
                done_vld = 1'b1;
                done_uop = held[u];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= '0;
            tmr  <= '0;
            for (int u = 0; u < NU; u++)
                held[u] <= '0;
        end else begin
            for (int u = 0; u < NU; u++) begin
                if (fin[u])
                    busy[u] <= 1'b0;
                else if (busy[u])
                    tmr[u] <= tmr[u] - TW'(1);
                if (take[u]) begin
                    busy[u] <= 1'b1;
                    tmr[u]  <= TW'(IL - 1);
                    held[u] <= grab_uop;
                end
            end
        end
    end

endmodule

// File: rtl/iq_pick.sv
module iq_pick
    import iss_pkg::*;
#(
    parameter int ISSUE_W = 2,
    parameter int CW      = 2
) (
    input  logic [NUM_CLS-1:0]            ready,
    input  logic [NUM_CLS-1:0][SEQ_W-1:0] seq,
    input  logic [NUM_CLS-1:0]            avail,
    input  logic [NUM_CLS-1:0]            occ,
    input  logic [CW-1:0]                 slot_cap,
    output logic [NUM_CLS-1:0]            pick,
    output logic [NUM_CLS-1:0]            busy_hit,
    output logic [NUM_CLS-1:0][CW-1:0]    slot_of,
    output logic [CW-1:0]                 npick
);

    logic [NUM_CLS-1:0][CLS_W-1:0] rank;
    logic [CW-1:0]                 slots;

    // Visit position = number of ready classes holding an older head
    always_comb begin
        for (int c = 0; c < NUM_CLS; c++) begin
            rank[c] = '0;
            for (int d = 0; d < NUM_CLS; d++) begin
                if (ready[d] && d != c &&
                    (seq[d] < seq[c] || (seq[d] == seq[c] && d < c)))
                    rank[c] = rank[c] + CLS_W'(1);
            end
        end
    end

    always_comb begin
        pick     = '0;
        busy_hit = '0;
        slot_of  = '0;
        npick    = '0;
        slots    = '0;
        for (int r = 0; r < NUM_CLS; r++) begin
            for (int c = 0; c < NUM_CLS; c++) begin
                if (ready[c] && rank[c] == CLS_W'(r) &&
                    npick < CW'(ISSUE_W) && slots < slot_cap) begin
                    if (avail[c]) begin
                        pick[c] = 1'b1;
                        npick   = npick + CW'(1);
                        if (occ[c]) begin
                            slot_of[c] = slots;
                            slots      = slots + CW'(1);
                        end
                    end else begin
                        busy_hit[c] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/iq_issue_select.sv
module iq_issue_select
    import iss_pkg::*;
#(
    parameter int ISSUE_W = 2,
    parameter int PUSH_W  = 4,
    parameter int QDEPTH  = 4,
    parameter int CNT_W   = 16,
    localparam int CW     = $clog2(ISSUE_W + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [PUSH_W-1:0]                 push_vld,
    input  logic [PUSH_W-1:0][CLS_W-1:0]      push_cls,
    input  logic [PUSH_W-1:0][SEQ_W-1:0]      push_seq,
    input  logic [PUSH_W-1:0][TID_W-1:0]      push_tid,
    output logic [ISSUE_W-1:0]                iss_vld,
    output logic [ISSUE_W-1:0][CLS_W-1:0]     iss_cls,
    output logic [ISSUE_W-1:0][SEQ_W-1:0]     iss_seq,
    output logic [ISSUE_W-1:0][TID_W-1:0]     iss_tid,
    output logic [CW-1:0]                     iss_count,
    output logic [NUM_CLS-1:0][CNT_W-1:0]     busy_cls,
    output logic [NUM_THR-1:0][CNT_W-1:0]     busy_thr
);

    localparam int TCW = $clog2(NUM_CLS + 1);

    uop_t                          push_uop  [PUSH_W];
    uop_t                          head      [NUM_CLS];
    uop_t                          done_uop  [NUM_CLS];
    uop_t                          comp_slot [ISSUE_W];
    uop_t                          slot_n    [ISSUE_W];
    logic [NUM_CLS-1:0]            head_vld;
    logic [NUM_CLS-1:0][SEQ_W-1:0] head_seq;
    logic [NUM_CLS-1:0]            avail;
    logic [NUM_CLS-1:0]            occ;
    logic [NUM_CLS-1:0]            done_vld;
    logic [NUM_CLS-1:0]            pick;
    logic [NUM_CLS-1:0]            busy_hit;
    logic [NUM_CLS-1:0][CW-1:0]    slot_of;
    logic [CW-1:0]                 npick;
    logic [CW-1:0]                 ncomp;
    logic [CW-1:0]                 slot_cap;
    logic [CW:0]                   pos;
    logic [NUM_THR-1:0][TCW-1:0]   thr_inc;

    always_comb begin
        for (int l = 0; l < PUSH_W; l++)
            push_uop[l] = '{vld: push_vld[l], cls: push_cls[l],
                            seq: push_seq[l], tid: push_tid[l]};
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        iq_class_q #(.CLS(c), .DEPTH(QDEPTH), .PUSH_W(PUSH_W)) u_q (
            .clk      (clk),
            .rst      (rst),
            .push_uop (push_uop),
            .pop      (pick[c]),
            .head_vld (head_vld[c]),
            .head_uop (head[c])
        );
        iq_unit_pool #(.CLS(c)) u_pool (
            .clk      (clk),
            .rst      (rst),
            .grab     (pick[c]),
            .grab_uop (head[c]),
            .avail    (avail[c]),
            .done_vld (done_vld[c]),
            .done_uop (done_uop[c])
        );
        assign head_seq[c] = head[c].seq;
        assign occ[c]      = (cls_kind(c) != KIND_HELD);
    end

    // Completions claim the lowest slots first
    always_comb begin
        ncomp = '0;
        for (int k = 0; k < ISSUE_W; k++)
            comp_slot[k] = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (done_vld[c] && ncomp < CW'(ISSUE_W)) begin
                comp_slot[ncomp] = done_uop[c];
                ncomp            = ncomp + CW'(1);
            end
        end
        slot_cap = CW'(ISSUE_W) - ncomp;
    end

    iq_pick #(.ISSUE_W(ISSUE_W), .CW(CW)) u_pick (
        .ready    (head_vld),
        .seq      (head_seq),
        .avail    (avail),
        .occ      (occ),
        .slot_cap (slot_cap),
        .pick     (pick),
        .busy_hit (busy_hit),
        .slot_of  (slot_of),
        .npick    (npick)
    );

    always_comb begin
        pos = '0;
        for (int k = 0; k < ISSUE_W; k++)
            slot_n[k] = comp_slot[k];
        for (int c = 0; c < NUM_CLS; c++) begin
            pos = {1'b0, ncomp} + {1'b0, slot_of[c]};
            if (pick[c] && occ[c] && pos < (CW+1)'(ISSUE_W))
                slot_n[pos[CW-1:0]] = head[c];
        end
    end

    always_comb begin
        for (int t = 0; t < NUM_THR; t++) begin
            thr_inc[t] = '0;
            for (int c = 0; c < NUM_CLS; c++)
                if (busy_hit[c] && head[c].tid == TID_W'(t))
                    thr_inc[t] = thr_inc[t] + TCW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_vld   <= '0;
            iss_cls   <= '0;
            iss_seq   <= '0;
            iss_tid   <= '0;
            iss_count <= '0;
            busy_cls  <= '0;
            busy_thr  <= '0;
        end else begin
            for (int k = 0; k < ISSUE_W; k++) begin
                iss_vld[k] <= slot_n[k].vld;
                iss_cls[k] <= slot_n[k].cls;
                iss_seq[k] <= slot_n[k].seq;
                iss_tid[k] <= slot_n[k].tid;
            end
            iss_count <= npick;
            for (int c = 0; c < NUM_CLS; c++)
                if (busy_hit[c])
                    busy_cls[c] <= busy_cls[c] + CNT_W'(1);
            for (int t = 0; t < NUM_THR; t++)
                busy_thr[t] <= busy_thr[t] + CNT_W'(thr_inc[t]);
        end
    end

endmodule

// File: rtl/iq_issue_chk.sv
module iq_issue_chk
    import iss_pkg::*;
#(
    parameter int ISSUE_W = 2,
    parameter int CW      = 2,
    parameter int CNT_W   = 16
) (
    input logic                          clk,
    input logic                          rst,
    input logic [ISSUE_W-1:0]            iss_vld,
    input logic [ISSUE_W-1:0][CLS_W-1:0] iss_cls,
    input logic [CW-1:0]                 iss_count,
    input logic [NUM_CLS-1:0][CNT_W-1:0] busy_cls,
    input logic [NUM_CLS-1:0]            avail,
    input logic [NUM_CLS-1:0]            pick,
    input logic [NUM_CLS-1:0]            done_vld
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (iss_vld == '0 && iss_count == '0));

    assert_count_cap_R4: assert property (@(posedge clk) disable iff (rst)
        iss_count <= CW'(ISSUE_W));

    assert_one_done_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(done_vld) <= 1);

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_c
        assert_pick_has_unit_R6: assert property (@(posedge clk) disable iff (rst)
            pick[c] |-> avail[c]);

        assert_busy_step_R9: assert property (@(posedge clk) disable iff (rst)
            (busy_cls[c] != $past(busy_cls[c])) |->
                (busy_cls[c] == $past(busy_cls[c]) + CNT_W'(1) && !$past(avail[c])));
    end

    for (genvar i = 0; i < ISSUE_W; i++) begin : g_i
        for (genvar j = i + 1; j < ISSUE_W; j++) begin : g_j
            assert_class_once_R3: assert property (@(posedge clk) disable iff (rst)
                (iss_vld[i] && iss_vld[j]) |-> (iss_cls[i] != iss_cls[j]));
        end
    end

endmodule

bind iq_issue_select iq_issue_chk #(.ISSUE_W(ISSUE_W), .CW(CW), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_vld   (iss_vld),
    .iss_cls   (iss_cls),
    .iss_count (iss_count),
    .busy_cls  (busy_cls),
    .avail     (avail),
    .pick      (pick),
    .done_vld  (done_vld)
);

// File: tb/iq_issue_select_tb.sv
module iq_issue_select_tb;
    import iss_pkg::*;

    localparam int ISSUE_W = 2;
    localparam int PUSH_W  = 4;
    localparam int CW      = $clog2(ISSUE_W + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [PUSH_W-1:0]                push_vld = '0;
    logic [PUSH_W-1:0][CLS_W-1:0]     push_cls = '0;
    logic [PUSH_W-1:0][SEQ_W-1:0]     push_seq = '0;
    logic [PUSH_W-1:0][TID_W-1:0]     push_tid = '0;
    logic [ISSUE_W-1:0]               iss_vld;
    logic [ISSUE_W-1:0][CLS_W-1:0]    iss_cls;
    logic [ISSUE_W-1:0][SEQ_W-1:0]    iss_seq;
    logic [ISSUE_W-1:0][TID_W-1:0]    iss_tid;
    logic [CW-1:0]                    iss_count;
    logic [NUM_CLS-1:0][15:0]         busy_cls;
    logic [NUM_THR-1:0][15:0]         busy_thr;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 0;

    always #2ns clk = ~clk;

    iq_issue_select #(.ISSUE_W(ISSUE_W), .PUSH_W(PUSH_W)) u_dut (
        .clk(clk), .rst(rst),
        .push_vld(push_vld), .push_cls(push_cls), .push_seq(push_seq), .push_tid(push_tid),
        .iss_vld(iss_vld), .iss_cls(iss_cls), .iss_seq(iss_seq), .iss_tid(iss_tid),
        .iss_count(iss_count), .busy_cls(busy_cls), .busy_thr(busy_thr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_lane(input int l, input int c, input int s, input int t);
        push_vld[l] = 1'b1;
        push_cls[l] = CLS_W'(c);
        push_seq[l] = SEQ_W'(s);
        push_tid[l] = TID_W'(t);
    endtask

    task automatic clear_lanes();
        push_vld = '0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Slot k: expect valid with given seq and class, or invalid when seq < 0
    task automatic chk_slot(input string req, input int k, input int s, input int c);
        if (s < 0) begin
            chk({req, " slot invalid"}, int'(iss_vld[k]), 0);
        end else begin
            chk({req, " slot valid"}, int'(iss_vld[k]), 1);
            chk({req, " slot seq"}, int'(iss_seq[k]), s);
            chk({req, " slot class"}, int'(iss_cls[k]), c);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 valid", int'(iss_vld), 0);
        chk("R1 count", int'(iss_count), 0);
        chk("R1 busy_cls", int'(busy_cls[3]), 0);
        chk("R1 busy_thr", int'(busy_thr[1]), 0);
    endtask

    task automatic t_age_order();
        set_lane(0, 3, 10, 0);
        set_lane(1, 1, 5, 0);
        set_lane(2, 2, 7, 0);
        set_lane(3, 0, 9, 0);
        step(1);
        clear_lanes();
        step(1);
        chk_slot("R3 oldest class first", 0, 5, 1);
        chk_slot("R10 second in visit order", 1, 7, 2);
        chk("R4 width cap count", int'(iss_count), 2);
        step(1);
        chk_slot("R5 no-unit class issues", 0, 9, 0);
        chk_slot("R6 held pick takes no slot", 1, -1, 0);
        chk("R7 count includes held pick", int'(iss_count), 2);
        step(2);
        chk("R6 not yet complete", int'(iss_vld), 0);
        step(1);
        chk_slot("R6 completion after 3 edges", 0, 10, 3);
        chk("R7 completion not counted", int'(iss_count), 0);
    endtask

    task automatic t_reorder();
        set_lane(0, 0, 70, 0);
        set_lane(1, 1, 75, 0);
        set_lane(2, 1, 90, 0);
        set_lane(3, 2, 80, 0);
        step(1);
        clear_lanes();
        set_lane(0, 1, 62, 0);
        step(1);
        clear_lanes();
        chk_slot("R3 first pair", 0, 70, 0);
        chk_slot("R3 first pair b", 1, 75, 1);
        step(1);
        chk_slot("R2 older push wins in class", 0, 62, 1);
        chk_slot("R3 class reordered", 1, 80, 2);
        step(1);
        chk_slot("R2 remaining entry", 0, 90, 1);
        chk("R4 single pick", int'(iss_count), 1);
    endtask

    task automatic t_pipe();
        set_lane(0, 2, 112, 0);
        set_lane(1, 2, 110, 0);
        set_lane(2, 2, 111, 0);
        set_lane(3, 0, 115, 0);
        step(1);
        clear_lanes();
        step(1);
        chk_slot("R5 pipelined first", 0, 110, 2);
        chk_slot("R5 no-unit beside it", 1, 115, 0);
        step(1);
        chk_slot("R5 pipelined back to back", 0, 111, 2);
        step(1);
        chk_slot("R5 pipelined third", 0, 112, 2);
        chk("R5 pipelined never busy", int'(busy_cls[2]), 0);
    endtask

    task automatic t_busy();
        set_lane(0, 3, 100, 1);
        set_lane(1, 3, 102, 1);
        set_lane(2, 3, 101, 1);
        step(1);
        clear_lanes();
        step(1);
        chk("R7 held pick count", int'(iss_count), 1);
        chk("R6 held pick no slot", int'(iss_vld), 0);
        step(1);
        chk("R7 second held pick", int'(iss_count), 1);
        step(1);
        chk("R9 busy class", int'(busy_cls[3]), 1);
        chk("R9 busy thread", int'(busy_thr[1]), 1);
        chk("R9 no pick while busy", int'(iss_count), 0);
        step(1);
        chk_slot("R6 first completion", 0, 100, 3);
        chk("R6 unit not reusable on completion edge", int'(busy_cls[3]), 2);
        step(1);
        chk_slot("R6 second completion", 0, 101, 3);
        chk("R6 freed unit picked next cycle", int'(iss_count), 1);
        chk("R9 thread 0 untouched", int'(busy_thr[0]), 0);
        step(3);
        chk_slot("R6 third completion", 0, 102, 3);
        chk("R9 busy final", int'(busy_cls[3]), 2);
    endtask

    task automatic t_slots_full();
        set_lane(0, 3, 200, 0);
        step(1);
        clear_lanes();
        step(2);
        set_lane(0, 1, 210, 0);
        set_lane(1, 2, 211, 0);
        step(1);
        clear_lanes();
        step(1);
        chk_slot("R8 completion in slot 0", 0, 200, 3);
        chk_slot("R8 one pick fits", 1, 210, 1);
        chk("R8 picks limited by slots", int'(iss_count), 1);
        chk("R4 unvisited class not busy", int'(busy_cls[2]), 0);
        step(1);
        chk_slot("R4 waiting class issues later", 0, 211, 2);
        step(1);
        chk("R2 idle count", int'(iss_count), 0);
    endtask

    initial begin
        t_reset();
        t_age_order();
        t_reorder();
        t_pipe();
        t_busy();
        t_slots_full();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule